// File: doc/BRIEF.md
# Interruptible Iterative Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor. It produces a 16-bit quotient and a 16-bit remainder. The operands can be signed or unsigned, and the result can be integer or fractional. The divide always runs a fixed sequence of 19 enabled cycles. The first cycle latches the operands and takes their magnitudes. The next sixteen cycles each produce one quotient bit by non-restoring subtraction or addition. One cycle corrects the remainder and the last cycle applies the signs and checks the range.

A per-cycle step enable sits beside the start command. Whenever the enable is low, the partial remainder, the quotient shift register, the phase and the step counter all hold their values. An interrupting agent can therefore take the divider's cycles away at any point and hand them back later. The final result is the same as for an uninterrupted divide.

There is a single error flag. It is raised for a zero divisor, for an integer quotient that does not fit, and for a fractional divide whose numerator magnitude is not below the divisor magnitude. Whenever the flag is raised, the outputs take fixed values.

Top module: `iter_divider`

## Requirements
- R1: A divide starts only on a clock edge where the block is idle and both `start` and `step_en` are high. `busy` is high from the next cycle. Otherwise an idle block stays idle.
- R2: `done` rises, and `busy` falls, right after the 19th edge with `step_en` high. The start edge counts as the first of these edges.
- R3: While `busy` is high and `step_en` is low, the internal state holds and `done` stays low. The result does not depend on where or how long the stalls occur.
- R4: In unsigned integer mode, the quotient and remainder are the truncated quotient and the remainder of the dividend divided by the divisor. `wide_mode`=1 uses all 32 dividend bits. `wide_mode`=0 uses only the low 16 bits.
- R5: In signed integer mode, the quotient is truncated toward zero. The remainder takes the sign of the dividend. The dividend is 32-bit two's complement when `wide_mode`=1, or its low 16 bits when `wide_mode`=0.
- R6: In unsigned fractional mode (`frac_mode`=1), the numerator n is the low 16 dividend bits. The quotient is floor(n·2^16/d) and the remainder is n·2^16 mod d. `wide_mode` is ignored.
- R7: In signed fractional mode, the quotient is n·2^15/d truncated toward zero (Q15). The remainder is n·2^15 − q·d.
- R8: In fractional mode, |n| ≥ |d| sets `err`. Whenever `err` is set, `quotient` is 16'hFFFF and `remainder` is 16'h0000.
- R9: A zero divisor sets `err` in every mode.
- R10: An integer quotient outside the 16-bit range sets `err`. The unsigned range is 0..65535 and the signed range is −32768..32767.
- R11: `quotient`, `remainder`, `err` and `done` hold until the next accepted start. `start` while `busy` is ignored, and the operand inputs are sampled only at the accepted start edge.
- R12: After reset, `busy`, `done` and `err` are 0, and `quotient` and `remainder` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide (with step_en, when idle) |
| step_en | input | 1 | Cycle enable for the sequence |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| wide_mode | input | 1 | 1: 32/16 integer divide, 0: 16/16 |
| frac_mode | input | 1 | 1: fractional divide |
| signed_mode | input | 1 | 1: two's-complement operands |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Result valid, held until next start |
| err | output | 1 | Divide-by-zero or overflow |

## Verification
A stall that does not fully freeze the state shows up as a wrong quotient or remainder. The same wrong value can also show up as an early or late `done`. In both cases it appears at the first completion after the stall, so every divide runs against a model that is stepped on every clock. A stall pattern drawn per cycle exposes lost enables within one divide. A counter or phase error shows up as a `done` edge that is off by one. A missed correction in the final two phases shows up as a remainder that is off by the divisor, or as a sign error. Both appear in the cycle `done` first rises.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ITER = 2'd1,
    PH_FIX  = 2'd2,
    PH_SIGN = 2'd3
  } div_phase_e;
endpackage

// File: rtl/div_operand_prep.sv
// Setup-cycle logic: operand magnitudes, result signs and range pre-check.
module div_operand_prep #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           wide_mode,
  input  logic           frac_mode,
  input  logic           signed_mode,
  output logic [2*W-1:0] num_mag,
  output logic [W-1:0]   den_mag,
  output logic           quo_neg,
  output logic           rem_neg,
  output logic           pre_err
);
  logic           n_sign;
  logic           d_sign;
  logic [W-1:0]   n_low_mag;
  logic [2*W-1:0] n_wide_mag;

  always_comb begin
    n_sign     = signed_mode & ((wide_mode & ~frac_mode) ? dividend[2*W-1] : dividend[W-1]);
    d_sign     = signed_mode & divisor[W-1];
    den_mag    = d_sign ? (~divisor + 1'b1) : divisor;
    n_low_mag  = n_sign ? (~dividend[W-1:0] + 1'b1) : dividend[W-1:0];
    n_wide_mag = n_sign ? (~dividend + 1'b1) : dividend;
    quo_neg    = n_sign ^ d_sign;
    rem_neg    = n_sign;
    if (frac_mode) begin
      if (signed_mode) begin
        num_mag = {1'b0, n_low_mag, {(W-1){1'b0}}};
      end else begin
        num_mag = {n_low_mag, {W{1'b0}}};
      end
      pre_err = (n_low_mag >= den_mag);
    end else begin
      if (wide_mode) begin
        num_mag = n_wide_mag;
      end else begin
        num_mag = {{W{1'b0}}, n_low_mag};
      end
      pre_err = (num_mag[2*W-1:W] >= den_mag);
    end
  end
endmodule

// File: rtl/div_nr_step.sv
// One non-restoring iteration: shift in a dividend bit, add or subtract the divisor.
module div_nr_step #(
  parameter int W = 16
) (
  input  logic [W+1:0] prem_in,
  input  logic [W-1:0] qsh_in,
  input  logic [W-1:0] den_mag,
  output logic [W+1:0] prem_out,
  output logic [W-1:0] qsh_out
);
  logic [W+1:0] shifted;
  logic [W+1:0] den_ext;

  always_comb begin
    shifted  = {prem_in[W:0], qsh_in[W-1]};
    den_ext  = {2'b00, den_mag};
    prem_out = prem_in[W+1] ? (shifted + den_ext) : (shifted - den_ext);
    qsh_out  = {qsh_in[W-2:0], ~prem_out[W+1]};
  end
endmodule

// File: rtl/div_sequencer.sv
// Phase and step counter; advances only on enabled cycles.
module div_sequencer
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       step_en,
  output div_phase_e phase,
  output logic       accept,
  output logic       finish
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    finish  = 1'b0;
    if (step_en) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            accept  = 1'b1;
            phase_d = PH_ITER;
            cnt_d   = '0;
          end
        end
        PH_ITER: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            phase_d = PH_FIX;
          end
        end
        PH_FIX:  phase_d = PH_SIGN;
        PH_SIGN: begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/div_result_fix.sv
// Final cycle: apply signs, detect signed range overflow, force error values.
module div_result_fix #(
  parameter int W = 16
) (
  input  logic [W-1:0] qmag,
  input  logic [W-1:0] rmag,
  input  logic         quo_neg,
  input  logic         rem_neg,
  input  logic         signed_mode,
  input  logic         pre_err,
  output logic [W-1:0] q_val,
  output logic [W-1:0] r_val,
  output logic         err_val
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic range_err;

  always_comb begin
    range_err = signed_mode & (quo_neg ? (qmag > HALF) : qmag[W-1]);
    err_val   = pre_err | range_err;
    if (err_val) begin
      q_val = '1;
      r_val = '0;
    end else begin
      q_val = (signed_mode & quo_neg) ? (~qmag + 1'b1) : qmag;
      r_val = (signed_mode & rem_neg) ? (~rmag + 1'b1) : rmag;
    end
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           step_en,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           wide_mode,
  input  logic           frac_mode,
  input  logic           signed_mode,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           busy,
  output logic           done,
  output logic           err
);
  localparam int PW = W + 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  div_phase_e phase;
  logic       accept, finish;

  div_sequencer #(.W(W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_q),
    .start   (start),
    .step_en (step_en),
    .phase   (phase),
    .accept  (accept),
    .finish  (finish)
  );

  logic [2*W-1:0] num_mag;
  logic [W-1:0]   den_mag_in;
  logic           quo_neg_in, rem_neg_in, pre_err_in;

  div_operand_prep #(.W(W)) u_prep (
    .dividend    (dividend),
    .divisor     (divisor),
    .wide_mode   (wide_mode),
    .frac_mode   (frac_mode),
    .signed_mode (signed_mode),
    .num_mag     (num_mag),
    .den_mag     (den_mag_in),
    .quo_neg     (quo_neg_in),
    .rem_neg     (rem_neg_in),
    .pre_err     (pre_err_in)
  );

  logic [PW-1:0] prem_q, prem_d, prem_step;
  logic [W-1:0]  qsh_q, qsh_d, qsh_step;
  logic [W-1:0]  den_q, den_d;
  logic          qneg_q, qneg_d, rneg_q, rneg_d, perr_q, perr_d, sgn_q, sgn_d;

  div_nr_step #(.W(W)) u_step (
    .prem_in  (prem_q),
    .qsh_in   (qsh_q),
    .den_mag  (den_q),
    .prem_out (prem_step),
    .qsh_out  (qsh_step)
  );

  logic [W-1:0] q_val, r_val;
  logic         err_val;

  div_result_fix #(.W(W)) u_fix (
    .qmag        (qsh_q),
    .rmag        (prem_q[W-1:0]),
    .quo_neg     (qneg_q),
    .rem_neg     (rneg_q),
    .signed_mode (sgn_q),
    .pre_err     (perr_q),
    .q_val       (q_val),
    .r_val       (r_val),
    .err_val     (err_val)
  );

  // datapath next state
  always_comb begin
    prem_d = prem_q;
    qsh_d  = qsh_q;
    den_d  = den_q;
    qneg_d = qneg_q;
    rneg_d = rneg_q;
    perr_d = perr_q;
    sgn_d  = sgn_q;
    if (accept) begin
      prem_d = {2'b00, num_mag[2*W-1:W]};
      qsh_d  = num_mag[W-1:0];
      den_d  = den_mag_in;
      qneg_d = quo_neg_in;
      rneg_d = rem_neg_in;
      perr_d = pre_err_in;
      sgn_d  = signed_mode;
    end else if (step_en) begin
      unique case (phase)
        PH_ITER: begin
          prem_d = prem_step;
          qsh_d  = qsh_step;
        end
        PH_FIX: begin
          if (prem_q[PW-1]) begin
            prem_d = prem_q + {2'b00, den_q};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      prem_q <= '0;
      qsh_q  <= '0;
      den_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      perr_q <= 1'b0;
      sgn_q  <= 1'b0;
    end else begin
      prem_q <= prem_d;
      qsh_q  <= qsh_d;
      den_q  <= den_d;
      qneg_q <= qneg_d;
      rneg_q <= rneg_d;
      perr_q <= perr_d;
      sgn_q  <= sgn_d;
    end
  end

  // output registers
  logic [W-1:0] quo_q, quo_d, rem_q, rem_d;
  logic         done_q, done_d, err_q, err_d;

  always_comb begin
    quo_d  = quo_q;
    rem_d  = rem_q;
    done_d = done_q;
    err_d  = err_q;
    if (accept) begin
      done_d = 1'b0;
    end else if (finish) begin
      quo_d  = q_val;
      rem_d  = r_val;
      err_d  = err_val;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      quo_q  <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign done      = done_q;
  assign err       = err_q;
  assign busy      = (phase != PH_IDLE);
endmodule

// File: rtl/iter_divider_chk.sv
module iter_divider_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_q,
  input logic           start,
  input logic           step_en,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [W-1:0]   quotient,
  input logic [W-1:0]   remainder,
  input logic [W+1:0]   prem_q,
  input logic [W-1:0]   qsh_q,
  input logic [1:0]     phase
);
  localparam int NCYC = W + 3;

  logic [7:0] en_cnt;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_cnt <= '0;
    end else if (!busy && start && step_en) begin
      en_cnt <= 8'd1;
    end else if (busy && step_en) begin
      en_cnt <= en_cnt + 8'd1;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy && start && step_en) |=> busy);  // R1
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy && !(start && step_en)) |=> !busy);  // R1
  AST_CYCLE_COUNT: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(done) |-> (en_cnt == 8'(NCYC)));  // R2
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && !step_en) |=> ($stable(prem_q) && $stable(qsh_q) && $stable(phase) && !done));  // R3
  AST_ERR_VALUES: assert property (@(posedge clk) disable iff (!rst_q)
    (done && err) |-> (quotient == '1 && remainder == '0));  // R8
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_q)
    !(busy && done));  // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (done && !(start && step_en)) |=> ($stable(quotient) && $stable(remainder) && $stable(err) && done));  // R11
endmodule

bind iter_divider iter_divider_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .start     (start),
  .step_en   (step_en),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .quotient  (quotient),
  .remainder (remainder),
  .prem_q    (prem_q),
  .qsh_q     (qsh_q),
  .phase     (phase)
);

// File: tb/test_iter_divider.sv
module test_iter_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 19;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        step_en = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        wide_mode = 1'b0, frac_mode = 1'b0, signed_mode = 1'b0;
  logic [15:0] quotient, remainder;
  logic        busy, done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_divider i_iter_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en),
    .dividend(dividend), .divisor(divisor), .wide_mode(wide_mode),
    .frac_mode(frac_mode), .signed_mode(signed_mode),
    .quotient(quotient), .remainder(remainder),
    .busy(busy), .done(done), .err(err)
  );

  int    n_tests = 0, n_fail = 0, cycles = 0;
  bit    chk_on = 1'b0;
  string cur_tag = "R4";

  // behavioural reference
  bit          m_busy = 0, m_done = 0, m_fresh = 0, m_err = 0, p_err = 0;
  int          m_cnt = 0;
  logic [15:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
  string       p_tag = "R4", m_tag = "R4";

  task automatic calc(input logic [31:0] dv, input logic [15:0] ds, input bit wm,
                      input bit fm, input bit sm, output logic [15:0] q,
                      output logic [15:0] r, output bit e);
    longint n, d, qq, rr;
    e = 0; qq = 0; rr = 0;
    if (fm) begin
      n = sm ? longint'($signed(dv[15:0])) : longint'(dv[15:0]);
      d = sm ? longint'($signed(ds)) : longint'(ds);
      if (((n < 0) ? -n : n) >= ((d < 0) ? -d : d)) e = 1;
      else begin
        qq = (n * (sm ? 32768 : 65536)) / d;
        rr = (n * (sm ? 32768 : 65536)) % d;
      end
    end else begin
      if (sm) n = wm ? longint'($signed(dv)) : longint'($signed(dv[15:0]));
      else    n = wm ? longint'(dv) : longint'(dv[15:0]);
      d = sm ? longint'($signed(ds)) : longint'(ds);
      if (d == 0) e = 1;
      else begin
        qq = n / d;
        rr = n % d;
        if (sm ? (qq > 32767 || qq < -32768) : (qq > 65535)) e = 1;
      end
    end
    q = e ? 16'hFFFF : qq[15:0];
    r = e ? 16'h0000 : rr[15:0];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_fresh = 0; m_err = 0; m_cnt = 0; m_q = '0; m_r = '0;
    end else begin
      m_fresh = 0;
      if (!m_busy && start && step_en) begin
        calc(dividend, divisor, wide_mode, frac_mode, signed_mode, p_q, p_r, p_err);
        p_tag = cur_tag;
        m_busy = 1; m_done = 0; m_cnt = 1;
      end else if (m_busy && step_en) begin
        m_cnt++;
        if (m_cnt == NCYC) begin
          m_busy = 0; m_done = 1; m_fresh = 1;
          m_q = p_q; m_r = p_r; m_err = p_err; m_tag = p_tag;
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (chk_on) begin
      check("R2", "busy", 32'(busy), 32'(m_busy));
      check(m_busy ? "R3" : "R2", "done", 32'(done), 32'(m_done));
      if (m_done) begin
        check(m_fresh ? m_tag : "R11", "quotient", 32'(quotient), 32'(m_q));
        check(m_fresh ? m_tag : "R11", "remainder", 32'(remainder), 32'(m_r));
        check(m_fresh ? m_tag : "R11", "err", 32'(err), 32'(m_err));
      end
    end
    if (cycles > WDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // stall: 0 none, 1 random, 2 long stall early and late
  task automatic run_div(input logic [31:0] dv, input logic [15:0] ds, input bit wm,
                         input bit fm, input bit sm, input int stall, input string tag);
    int k;
    @(negedge clk);
    cur_tag = tag;
    dividend = dv; divisor = ds; wide_mode = wm; frac_mode = fm; signed_mode = sm;
    start = 1; step_en = 1;
    @(negedge clk);
    start = 0;
    dividend = ~dv; divisor = ~ds;   // operands must already be latched (R11)
    k = 0;
    while (m_busy) begin
      if (stall == 1) step_en = ($urandom % 3) != 0;
      else if (stall == 2) step_en = !((k >= 2 && k < 9) || (k >= 20 && k < 24));
      else step_en = 1;
      k++;
      @(negedge clk);
    end
    step_en = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R12: reset values
    check("R12", "busy", 32'(busy), 0);
    check("R12", "done", 32'(done), 0);
    check("R12", "err", 32'(err), 0);
    check("R12", "quotient", 32'(quotient), 0);
    check("R12", "remainder", 32'(remainder), 0);
    chk_on = 1;

    // R1: start with step_en low is not accepted
    start = 1; step_en = 0; dividend = 32'd100; divisor = 16'd7;
    @(negedge clk);
    check("R1", "busy after gated start", 32'(busy), 0);
    start = 0;
    @(negedge clk);

    run_div(32'd100, 16'd7, 1, 0, 0, 0, "R4");
    run_div(32'h0012_3456, 16'h1234, 1, 0, 0, 0, "R4");
    run_div(32'hFFFF_0000, 16'hFFFF, 1, 0, 0, 1, "R4");
    run_div(32'hABCD_9876, 16'd3, 0, 0, 0, 0, "R4");
    run_div(32'd5, 16'd9, 0, 0, 0, 0, "R4");
    run_div(-32'sd1000, 16'd7, 1, 0, 1, 0, "R5");
    run_div(32'd1000, -16'sd7, 1, 0, 1, 1, "R5");
    run_div(-32'sd1000, -16'sd7, 1, 0, 1, 0, "R5");
    run_div(32'h0000_8000, 16'h7FFF, 0, 0, 1, 0, "R5");
    run_div(-32'sd65536, 16'd2, 1, 0, 1, 0, "R5");
    run_div(32'h0000_4000, 16'h8000, 1, 1, 0, 0, "R6");
    run_div(32'd1, 16'd3, 0, 1, 0, 1, "R6");
    run_div(32'h0000_C000, -16'sd32768, 0, 1, 1, 0, "R7");
    run_div(32'h0000_2000, 16'h6000, 0, 1, 1, 2, "R7");
    run_div(32'h0000_E000, 16'h3000, 0, 1, 1, 0, "R7");
    run_div(32'd9, 16'd9, 0, 1, 0, 0, "R8");
    run_div(32'h0000_8000, 16'h8000, 0, 1, 1, 0, "R8");
    run_div(32'd1234, 16'd0, 1, 0, 0, 0, "R9");
    run_div(32'd1234, 16'd0, 0, 0, 1, 1, "R9");
    run_div(32'd0, 16'd0, 0, 1, 0, 0, "R9");
    run_div(32'h0001_0000, 16'd1, 1, 0, 0, 0, "R10");
    run_div(32'h0000_8000, 16'hFFFF, 0, 0, 1, 0, "R10");
    run_div(32'h0000_8000, 16'd1, 1, 0, 1, 0, "R10");
    // R3: identical operands under different stall patterns
    run_div(32'h7654_3210, 16'h9ABC, 1, 0, 0, 2, "R3");
    run_div(-32'sd123456, 16'd321, 1, 0, 1, 2, "R3");
    for (int i = 0; i < 40; i++) begin
      run_div($urandom, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              int'($urandom % 3), "R3");
    end

    // R11: start while busy ignored
    @(negedge clk);
    cur_tag = "R11";
    dividend = 32'd77; divisor = 16'd5; wide_mode = 0; frac_mode = 0; signed_mode = 0;
    start = 1; step_en = 1;
    @(negedge clk);
    dividend = 32'd999; divisor = 16'd1;
    repeat (5) @(negedge clk);
    start = 0;
    while (m_busy) @(negedge clk);
    check("R11", "quotient of first start", 32'(quotient), 32'd15);
    step_en = 0;
    repeat (6) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule